// File: doc/BRIEF.md
# SONET Section Framing Defect Monitor

This block follows the framing health of an STS-3 receive stream one frame at a time. For every frame boundary the receive framer gives a strobe and a flag that tells whether that frame's A1/A2 alignment bytes were free of errors. From these the block keeps two defect states: Severely Errored Frame (SEF), which tracks short runs of bad or good frames, and Loss of Frame (LOF), which follows SEF over a span of about 3 ms. It also passes through a loss-of-signal flag (LOS) so that software sees all three in one place.

Software reads the current defect state from a read-only status register. Every rise or fall of any of the three defects is latched in an interrupt status register, which clears when it is read. An enable register masks each latched bit, and any bit that is both pending and enabled pulls a shared active-low interrupt pin. The bus is a plain select / write / address / data port with the read data driven combinationally.

Top module: `frmDefectTop`

## Requirements
- R1: After reset the status register (address 0) and the interrupt status register (address 1) read 0x00, the enable register (address 2) reads 0x00, and intN is high.
- R2: While SEF is clear, SEF is declared on the 4th consecutive frame strobe with alignOk low; a frame with alignOk high restarts the run.
- R3: While SEF is declared, SEF clears on the 2nd consecutive frame strobe with alignOk high; an errored frame restarts the run.
- R4: LOF is declared on the 24th consecutive frame strobe in which SEF is declared and not clearing (with 125 us frames, 3 ms); a clearance of SEF restarts this count.
- R5: LOF clears on the 24th consecutive frame strobe in which SEF is absent and not being declared; a new declaration of SEF restarts this count.
- R6: Status register at address 0: bit 0 is LOS (losIn delayed one clock), bit 1 is SEF, bit 2 is LOF, bits 7 to 3 read 0; writes to address 0 have no effect.
- R7: Each declaration or clearance of LOS, SEF or LOF sets bit 0, 1 or 2 of the interrupt status register in the clock where the status bit changes.
- R8: A read of address 1 returns the pending bits and clears them at the clock edge ending the read; a bit whose event falls in that same clock stays set.
- R9: The enable register at address 2 holds bits 2 to 0 (bits 7 to 3 read 0); a disabled bit still latches in address 1 but does not pull intN low.
- R10: intN is low exactly when some interrupt status bit and its enable bit are both 1.
- R11: alignOk has no effect in clocks where frameStrobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStrobe | input | 1 | One-clock pulse per received frame |
| alignOk | input | 1 | A1/A2 bytes of this frame were error-free (valid with frameStrobe) |
| losIn | input | 1 | Loss-of-signal flag from the line side |
| busSel | input | 1 | Register access in this clock |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| intN | output | 1 | Active-low interrupt |

## Verification
The two functions that can meet in one clock are the clear-on-read of the interrupt status register and the latching of a new defect transition. The bench provokes this by raising losIn in the very clock that reads address 1 after it has been emptied: the read must return the old value, and a second read must show bit 0 still set. The same reasoning covers SEF and LOF events, since all three bits share the one set-over-clear rule.

// File: rtl/frmDefectPkg.sv
package frmDefectPkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_INT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd2;

  localparam int BIT_LOS = 0;
  localparam int BIT_SEF = 1;
  localparam int BIT_LOF = 2;
  localparam int DEF_N   = 3;

  typedef struct packed {
    logic sefSet;
    logic sefClr;
    logic lofSet;
    logic lofClr;
  } defEvt_t;
endpackage

// File: rtl/frmDefectCtrl.sv
module frmDefectCtrl
  import frmDefectPkg::*;
#(
  parameter int SEF_DECL_FRAMES = 4,
  parameter int SEF_CLR_FRAMES  = 2,
  parameter int LOF_FRAMES      = 24
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameStrobe,
  input  logic    alignOk,
  input  logic    sef,
  input  logic    lof,
  output defEvt_t evt
);
  localparam int BAD_W  = $clog2(SEF_DECL_FRAMES + 1);
  localparam int GOOD_W = $clog2(SEF_CLR_FRAMES + 1);
  localparam int TIM_W  = $clog2(LOF_FRAMES + 1);
  localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(SEF_DECL_FRAMES - 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(SEF_CLR_FRAMES - 1);
  localparam logic [TIM_W-1:0]  TIM_LAST  = TIM_W'(LOF_FRAMES - 1);

  logic [BAD_W-1:0]  badRun;
  logic [GOOD_W-1:0] goodRun;
  logic [TIM_W-1:0]  lofTimer;
  logic [TIM_W-1:0]  clrTimer;
  logic              inSefSpan;
  logic              outSefSpan;

  always_comb begin
    evt.sefSet = frameStrobe && !sef && !alignOk && (badRun == BAD_LAST);
    evt.sefClr = frameStrobe && sef && alignOk && (goodRun == GOOD_LAST);
    inSefSpan  = sef && !evt.sefClr;
    outSefSpan = !sef && !evt.sefSet;
    evt.lofSet = frameStrobe && inSefSpan && !lof && (lofTimer == TIM_LAST);
    evt.lofClr = frameStrobe && outSefSpan && lof && (clrTimer == TIM_LAST);
  end

  // Run counters for SEF entry and exit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badRun  <= '0;
      goodRun <= '0;
    end else if (frameStrobe) begin
      if (!sef) begin
        goodRun <= '0;
        if (alignOk || badRun == BAD_LAST) badRun <= '0;
        else                               badRun <= badRun + 1'b1;
      end else begin
        badRun <= '0;
        if (!alignOk || goodRun == GOOD_LAST) goodRun <= '0;
        else                                  goodRun <= goodRun + 1'b1;
      end
    end
  end

  // Frame-count timers for LOF entry and exit (saturating)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lofTimer <= '0;
      clrTimer <= '0;
    end else if (frameStrobe) begin
      if (inSefSpan) begin
        if (lofTimer != TIM_LAST) lofTimer <= lofTimer + 1'b1;
      end else begin
        lofTimer <= '0;
      end
      if (outSefSpan && lof) begin
        if (clrTimer != TIM_LAST) clrTimer <= clrTimer + 1'b1;
      end else begin
        clrTimer <= '0;
      end
    end
  end

  p_sef_set_from_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    evt.sefSet |=> sef);
  p_sef_clr_from_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    evt.sefClr |=> !sef);
  p_bad_run_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    badRun <= BAD_LAST);
  p_no_count_without_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> ($stable(badRun) && $stable(goodRun) && $stable(lofTimer)));
endmodule

// File: rtl/frmDefectRegs.sv
module frmDefectRegs
  import frmDefectPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  defEvt_t           evt,
  input  logic              losIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sef,
  output logic              lof,
  output logic              intN
);
  logic             losQ;
  logic [DEF_N-1:0] intStat;
  logic [DEF_N-1:0] intEn;
  logic [DEF_N-1:0] setVec;
  logic [DEF_N-1:0] statVec;
  logic             rdInt;
  logic             wrEn;

  always_comb begin
    rdInt   = busSel && !busWr && (busAddr == ADDR_INT);
    wrEn    = busSel && busWr && (busAddr == ADDR_EN);
    setVec  = '0;
    setVec[BIT_LOS] = losIn ^ losQ;
    setVec[BIT_SEF] = evt.sefSet | evt.sefClr;
    setVec[BIT_LOF] = evt.lofSet | evt.lofClr;
    statVec = '0;
    statVec[BIT_LOS] = losQ;
    statVec[BIT_SEF] = sef;
    statVec[BIT_LOF] = lof;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sef  <= 1'b0;
      lof  <= 1'b0;
      losQ <= 1'b0;
    end else begin
      losQ <= losIn;
      if (evt.sefSet)      sef <= 1'b1;
      else if (evt.sefClr) sef <= 1'b0;
      if (evt.lofSet)      lof <= 1'b1;
      else if (evt.lofClr) lof <= 1'b0;
    end
  end

  // A new event wins over the clear caused by a read in the same clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intStat <= '0;
    else       intStat <= setVec | (intStat & ~{DEF_N{rdInt}});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     intEn <= '0;
    else if (wrEn) intEn <= busWdata[DEF_N-1:0];
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_STAT: busRdata[DEF_N-1:0] = statVec;
      ADDR_INT:  busRdata[DEF_N-1:0] = intStat;
      ADDR_EN:   busRdata[DEF_N-1:0] = intEn;
      default:   busRdata = '0;
    endcase
  end

  assign intN = ~|(intStat & intEn);

  p_sef_edge_latched_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sef != $past(sef)) |-> intStat[BIT_SEF]);
  p_lof_edge_latched_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lof != $past(lof)) |-> intStat[BIT_LOF]);
  p_lof_rises_in_sef_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lof) |-> $past(sef));
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdInt && setVec == '0) |=> intStat == '0);
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:DEF_N] == '0);
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == '0) |-> intN);
endmodule

// File: rtl/frmDefectTop.sv
module frmDefectTop
  import frmDefectPkg::*;
#(
  parameter int SEF_DECL_FRAMES = 4,
  parameter int SEF_CLR_FRAMES  = 2,
  parameter int LOF_FRAMES      = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStrobe,
  input  logic              alignOk,
  input  logic              losIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              intN
);
  defEvt_t evt;
  logic    sef;
  logic    lof;

  frmDefectCtrl #(
    .SEF_DECL_FRAMES(SEF_DECL_FRAMES),
    .SEF_CLR_FRAMES (SEF_CLR_FRAMES),
    .LOF_FRAMES     (LOF_FRAMES)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStrobe(frameStrobe),
    .alignOk    (alignOk),
    .sef        (sef),
    .lof        (lof),
    .evt        (evt)
  );

  frmDefectRegs uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .losIn   (losIn),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .sef     (sef),
    .lof     (lof),
    .intN    (intN)
  );
endmodule

// File: tb/sim_frmDefectTop.sv
module sim_frmDefectTop;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStrobe = 1'b0;
  logic       alignOk = 1'b0;
  logic       losIn = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       intN;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frmDefectTop u0 (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .alignOk(alignOk),
    .losIn(losIn), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .intN(intN)
  );

  // bit1 = alignOk of the frame, bit0 = expected SEF after it
  localparam logic [1:0] VEC [0:11] = '{
    2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00,
    2'b00, 2'b01, 2'b11, 2'b01, 2'b11, 2'b10
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic ok);
    @(negedge clk);
    frameStrobe = 1'b1;
    alignOk = ok;
    @(negedge clk);
    frameStrobe = 1'b0;
    alignOk = 1'b0;
  endtask

  task automatic frames(input logic ok, input int n);
    for (int i = 0; i < n; i++) frame(ok);
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 v = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(2'd0, v); chk("R1 status", v, 8'h00);
    rdReg(2'd1, v); chk("R1 intstat", v, 8'h00);
    rdReg(2'd2, v); chk("R1 enable", v, 8'h00);
    chk("R1 intN", {7'd0, intN}, 8'h01);

    // R2/R3 table walk
    for (int i = 0; i < 12; i++) begin
      frame(VEC[i][1]);
      rdReg(2'd0, v);
      chk("R2 R3 table sef", {6'd0, v[1], 1'b0}, {6'd0, VEC[i][0], 1'b0});
    end

    // R7 / R8 / R9: two SEF edges latched, masked, clear on read
    chk("R9 masked intN", {7'd0, intN}, 8'h01);
    rdReg(2'd1, v); chk("R7 sef edges", v, 8'h02);
    rdReg(2'd1, v); chk("R8 cleared", v, 8'h00);

    // R6 / R9 register map
    wrReg(2'd0, 8'hFF);
    rdReg(2'd0, v); chk("R6 status write ignored", v, 8'h00);
    wrReg(2'd2, 8'hFF);
    rdReg(2'd2, v); chk("R9 enable readback", v, 8'h07);

    // R4 LOF declaration
    frames(1'b0, 27);
    rdReg(2'd0, v); chk("R4 no lof yet", v, 8'h02);
    frame(1'b0);
    rdReg(2'd0, v); chk("R4 lof declared", v, 8'h06);
    chk("R10 intN low", {7'd0, intN}, 8'h00);
    rdReg(2'd1, v); chk("R7 sef lof edges", v, 8'h06);
    chk("R10 intN high after read", {7'd0, intN}, 8'h01);

    // R11 alignOk without strobe
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); alignOk = 1'b1;
    end
    @(negedge clk); alignOk = 1'b0;
    rdReg(2'd0, v); chk("R11 no effect", v, 8'h06);

    // R5 LOF clearance with restart
    frames(1'b1, 2);
    rdReg(2'd0, v); chk("R3 sef cleared lof held", v, 8'h04);
    frames(1'b1, 10);
    frames(1'b0, 4);
    rdReg(2'd0, v); chk("R5 sef back", v, 8'h06);
    frames(1'b1, 2);
    frames(1'b1, 23);
    rdReg(2'd0, v); chk("R5 restarted count", v, 8'h04);
    frame(1'b1);
    rdReg(2'd0, v); chk("R5 lof cleared", v, 8'h00);
    rdReg(2'd1, v); chk("R7 lof clear latched", v, 8'h06);

    // R8 read and LOS event in the same clock
    @(negedge clk);
    losIn = 1'b1; busSel = 1'b1; busWr = 1'b0; busAddr = 2'd1;
    #1 v = busRdata;
    chk("R8 read before event", v, 8'h00);
    @(negedge clk);
    busSel = 1'b0;
    rdReg(2'd1, v); chk("R8 event kept", v, 8'h01);
    rdReg(2'd0, v); chk("R6 los status", v, 8'h01);

    // R9 mask LOS only
    wrReg(2'd2, 8'h06);
    losIn = 1'b0;
    @(negedge clk);
    chk("R9 masked los intN", {7'd0, intN}, 8'h01);
    rdReg(2'd1, v); chk("R9 still latched", v, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule